// File: doc/BRIEF.md
# Escalating Watchdog with Boot-Failure Recovery

This block is a countdown watchdog with two stages of escalation. A down-counter runs from a software-programmed reload value. When it expires the first time, a timeout flag is latched and a system-management interrupt request is raised. The counter then reloads on its own and keeps running. If it expires again while the first timeout is still unacknowledged, the block latches a second-timeout flag. Unless reboot is disabled, it also drives a fixed-length platform reset pulse.

The block tracks whether the processor has fetched its first instruction since the last system reset. If the second timeout arrives before that fetch, a boot-failure flag is latched. While that flag is set, any reset pulse the block issues carries a fixed safe clock-multiplier code instead of the configured one. Software uses three registers on a plain register bus: status (write-one-to-clear), control, and reload. It services the watchdog with a kick strobe.

The block has two resets. The resume-well reset clears everything. The system reset, which is either the external input or the block's own reset pulse, restarts the counter and clears the first-timeout flag and the fetch tracker. The second-timeout and boot-failure flags survive the system reset.

Top module: `wdog_escalator`

## Requirements
- R1: After the resume-well reset, status reads 0000h, control reads 0002h, `smi_o` and `plat_rst_o` are 0.
- R2: A kick loads the counter with the reload value N. The TIMEOUT status bit (bit 0) reads 1 after the (N+1)th rising edge following the kick edge, and not before.
- R3: `smi_o` is 1 exactly when control bit 1 (SMI enable) is 1 and TIMEOUT or SECOND (bit 1) is set.
- R4: After the first expiry the counter reloads itself. A further expiry while TIMEOUT is still set sets SECOND (status bit 1) N+1 edges after the first.
- R5: When SECOND is set by an expiry and control bit 0 (no-reboot) is 0, `plat_rst_o` is 1 for exactly 16 cycles, starting in the same cycle SECOND becomes visible. With no-reboot at 1, no pulse occurs.
- R6: BOOT (status bit 2) is set together with a 0-to-1 change of SECOND only if `first_fetch_i` has not pulsed since the last system reset.
- R7: While `plat_rst_o` is 1 and BOOT is set, `mult_o` is 4'b1111. Otherwise `mult_o` equals `mult_cfg_i`.
- R8: Writing to status (address 0) clears each bit written as 1 and leaves bits written as 0 unchanged. Bits 15:3 always read 0.
- R9: A write of 1 to BOOT has no effect while SECOND is set.
- R10: The system reset (`rst_sys_n` low, or the block's own pulse) clears TIMEOUT but keeps SECOND and BOOT. The resume-well reset clears all of them.
- R11: Kicks given before the count reaches zero prevent any expiry.
- R12: The register map is: address 0 status, address 1 control (bit 0 no-reboot, bit 1 SMI enable), address 2 reload value. Reads are combinational on `reg_sel`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_well_n | input | 1 | Resume-well reset, asynchronous, active low, clears all state |
| rst_sys_n | input | 1 | System reset, synchronous, active low |
| reg_sel | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected register |
| kick_i | input | 1 | Service strobe, reloads the counter |
| first_fetch_i | input | 1 | Processor fetched its first instruction |
| mult_cfg_i | input | 4 | Configured clock-multiplier code |
| mult_o | output | 4 | Multiplier code presented to the platform |
| smi_o | output | 1 | System-management interrupt request, level |
| plat_rst_o | output | 1 | Platform reset pulse |

## Verification
A counter that is off by one moves the TIMEOUT bit by a cycle, so an exact-edge read of status after a kick exposes it within one period. A wrong escalation decision shows at the next expiry. It appears as a missing or unwanted SECOND or BOOT bit, or as a reset pulse whose length or presence is wrong, visible over the following 16 cycles. A wrong clear policy shows on the first read after a write-one-to-clear, or after a system reset.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned REG_DW = 16;
  localparam logic [1:0] ADDR_STAT   = 2'd0;
  localparam logic [1:0] ADDR_CTRL   = 2'd1;
  localparam logic [1:0] ADDR_RELOAD = 2'd2;
  localparam int unsigned ST_TMO  = 0;
  localparam int unsigned ST_SEC  = 1;
  localparam int unsigned ST_BOOT = 2;
  localparam int unsigned CT_NOREBOOT = 0;
  localparam int unsigned CT_SMIEN    = 1;
  localparam logic [3:0] SAFE_MULT = 4'b1111;
endpackage

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CW = 16,
  parameter logic [CW-1:0] RST_VAL = '1
) (
  input  logic          clk,
  input  logic          rst_well_n,
  input  logic          sys_clr,
  input  logic          kick_i,
  input  logic [CW-1:0] reload_i,
  output logic          expire_o
);
  logic [CW-1:0] cnt;

  assign expire_o = (cnt == '0) && !kick_i && !sys_clr;

  always_ff @(posedge clk or negedge rst_well_n) begin
    if (!rst_well_n)                       cnt <= RST_VAL;
    else if (sys_clr || kick_i || cnt == '0) cnt <= reload_i;
    else                                   cnt <= cnt - 1'b1;
  end

  AST_RELOAD_AFTER_EXPIRE: assert property (@(posedge clk) disable iff (!rst_well_n)
    expire_o |=> cnt == $past(reload_i)); // R4
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter logic [CW-1:0] RELOAD_DEF = '1
) (
  input  logic              clk,
  input  logic              rst_well_n,
  input  logic              sys_clr,
  input  logic [1:0]        reg_sel,
  input  logic              reg_wr,
  input  logic [REG_DW-1:0] reg_wdata,
  output logic [REG_DW-1:0] reg_rdata,
  input  logic              expire_i,
  input  logic              first_fetch_i,
  output logic [CW-1:0]     reload_o,
  output logic              smi_o,
  output logic              sec_o,
  output logic              boot_o,
  output logic              reboot_req_o
);
  logic tmo, sec, boot, fetched;
  logic no_reboot, smi_en;
  logic [CW-1:0] reload_q;
  logic wr_stat, second_evt;

  assign wr_stat    = reg_wr && (reg_sel == ADDR_STAT);
  assign second_evt = expire_i && tmo;

  always_ff @(posedge clk or negedge rst_well_n) begin
    if (!rst_well_n) begin
      tmo <= 1'b0; sec <= 1'b0; boot <= 1'b0; fetched <= 1'b0;
    end else begin
      if (sys_clr)                           tmo <= 1'b0;
      else if (expire_i)                     tmo <= 1'b1;
      else if (wr_stat && reg_wdata[ST_TMO]) tmo <= 1'b0;

      if (second_evt)                        sec <= 1'b1;
      else if (wr_stat && reg_wdata[ST_SEC]) sec <= 1'b0;

      if (second_evt && !sec && !fetched)                boot <= 1'b1;
      else if (wr_stat && reg_wdata[ST_BOOT] && !sec)    boot <= 1'b0;

      if (sys_clr)            fetched <= 1'b0;
      else if (first_fetch_i) fetched <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_well_n) begin
    if (!rst_well_n) begin
      no_reboot <= 1'b0; smi_en <= 1'b1; reload_q <= RELOAD_DEF;
    end else if (reg_wr) begin
      if (reg_sel == ADDR_CTRL) begin
        no_reboot <= reg_wdata[CT_NOREBOOT];
        smi_en    <= reg_wdata[CT_SMIEN];
      end
      if (reg_sel == ADDR_RELOAD) reload_q <= reg_wdata[CW-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      ADDR_STAT: begin
        reg_rdata[ST_TMO]  = tmo;
        reg_rdata[ST_SEC]  = sec;
        reg_rdata[ST_BOOT] = boot;
      end
      ADDR_CTRL: begin
        reg_rdata[CT_NOREBOOT] = no_reboot;
        reg_rdata[CT_SMIEN]    = smi_en;
      end
      ADDR_RELOAD: reg_rdata = REG_DW'(reload_q);
      default: reg_rdata = '0;
    endcase
  end

  assign reload_o     = reload_q;
  assign smi_o        = smi_en && (tmo || sec);
  assign sec_o        = sec;
  assign boot_o       = boot;
  assign reboot_req_o = second_evt && !no_reboot;

  AST_BOOT_WITH_SEC: assert property (@(posedge clk) disable iff (!rst_well_n)
    $rose(boot) |-> sec); // R6
  AST_BOOT_LOCKED: assert property (@(posedge clk) disable iff (!rst_well_n)
    (boot && sec) |=> boot); // R9
  AST_TMO_SYS_CLEAR: assert property (@(posedge clk) disable iff (!rst_well_n)
    $past(sys_clr) |-> !tmo); // R10
endmodule

// File: rtl/wdog_rst_pulse.sv
module wdog_rst_pulse #(
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic clk,
  input  logic rst_well_n,
  input  logic start_i,
  output logic active_o
);
  localparam int unsigned PW = $clog2(PULSE_LEN + 1);
  logic [PW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_well_n) begin
    if (!rst_well_n)                 cnt <= '0;
    else if (start_i && cnt == '0)   cnt <= PW'(PULSE_LEN);
    else if (cnt != '0)              cnt <= cnt - 1'b1;
  end

  assign active_o = (cnt != '0);

  AST_PULSE_FROM_START: assert property (@(posedge clk) disable iff (!rst_well_n)
    $rose(active_o) |-> $past(start_i)); // R5
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (!rst_well_n)
    active_o |-> !start_i); // R5
endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
  import wdog_pkg::*;
#(
  parameter int unsigned CW = 16,
  parameter logic [CW-1:0] RELOAD_DEF = CW'(1023),
  parameter int unsigned PULSE_LEN = 16
) (
  input  logic        clk,
  input  logic        rst_well_n,
  input  logic        rst_sys_n,
  input  logic [1:0]  reg_sel,
  input  logic        reg_wr,
  input  logic [15:0] reg_wdata,
  output logic [15:0] reg_rdata,
  input  logic        kick_i,
  input  logic        first_fetch_i,
  input  logic [3:0]  mult_cfg_i,
  output logic [3:0]  mult_o,
  output logic        smi_o,
  output logic        plat_rst_o
);
  logic sys_clr, expire, reboot_req, sec, boot;
  logic [CW-1:0] reload;

  assign sys_clr = !rst_sys_n || plat_rst_o;

  wdog_counter #(.CW(CW), .RST_VAL(RELOAD_DEF)) i_cnt (
    .clk(clk), .rst_well_n(rst_well_n), .sys_clr(sys_clr),
    .kick_i(kick_i), .reload_i(reload), .expire_o(expire));

  wdog_regs #(.CW(CW), .RELOAD_DEF(RELOAD_DEF)) i_regs (
    .clk(clk), .rst_well_n(rst_well_n), .sys_clr(sys_clr),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .expire_i(expire), .first_fetch_i(first_fetch_i),
    .reload_o(reload), .smi_o(smi_o), .sec_o(sec), .boot_o(boot),
    .reboot_req_o(reboot_req));

  wdog_rst_pulse #(.PULSE_LEN(PULSE_LEN)) i_pulse (
    .clk(clk), .rst_well_n(rst_well_n), .start_i(reboot_req),
    .active_o(plat_rst_o));

  assign mult_o = (plat_rst_o && boot) ? SAFE_MULT : mult_cfg_i;

  AST_RST_AFTER_SECOND: assert property (@(posedge clk) disable iff (!rst_well_n)
    $rose(plat_rst_o) |-> sec); // R5
endmodule

// File: tb/test_wdog_escalator.sv
module test_wdog_escalator;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_well_n = 1'b0, rst_sys_n = 1'b1;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0, reg_rdata;
  logic kick_i = 1'b0, first_fetch_i = 1'b0;
  logic [3:0] mult_cfg_i = 4'h3, mult_o;
  logic smi_o, plat_rst_o;
  int total = 0, bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdog_escalator i_wdog_escalator (
    .clk(clk), .rst_well_n(rst_well_n), .rst_sys_n(rst_sys_n),
    .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .kick_i(kick_i), .first_fetch_i(first_fetch_i),
    .mult_cfg_i(mult_cfg_i), .mult_o(mult_o), .smi_o(smi_o),
    .plat_rst_o(plat_rst_o));

  function automatic int exp_expire_edges(int n);
    return n + 1;
  endfunction

  function automatic logic exp_smi(logic en, logic [15:0] st);
    return en && (st[0] || st[1]);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic edges(int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d);
    reg_sel = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    reg_sel = a; #1; d = reg_rdata;
  endtask

  task automatic kick();
    kick_i = 1'b1; @(posedge clk); @(negedge clk); kick_i = 1'b0;
  endtask

  task automatic well_reset();
    rst_well_n = 1'b0; #2; rst_well_n = 1'b1; @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    int n;
    void'($urandom(32'd4242));
    @(negedge clk); @(negedge clk);
    rst_well_n = 1'b1;
    @(negedge clk);

    // R1 reset state, R12 map
    rd(2'd0, d); chk("R1 status", d, 16'h0000);
    rd(2'd1, d); chk("R1 ctrl", d, 16'h0002);
    chk("R1 smi", smi_o, 1'b0);
    chk("R1 plat_rst", plat_rst_o, 1'b0);

    // Directed: escalation with reboot, no fetch
    n = 9;
    wr(2'd2, 16'(n));
    rd(2'd2, d); chk("R12 reload", d, 16'(n));
    kick();
    edges(exp_expire_edges(n) - 1);
    rd(2'd0, d); chk("R2 tmo early", d[0], 1'b0);
    edges(1);
    rd(2'd0, d); chk("R2 tmo set", d[0], 1'b1);
    chk("R3 smi on tmo", smi_o, exp_smi(1'b1, d));
    edges(exp_expire_edges(n) - 1);
    rd(2'd0, d); chk("R4 sec early", d[1], 1'b0);
    edges(1);
    rd(2'd0, d); chk("R4 sec set", d[1], 1'b1);
    chk("R6 boot set", d[2], 1'b1);
    chk("R5 pulse start", plat_rst_o, 1'b1);
    chk("R7 safe mult", mult_o, 4'hF);
    wr(2'd2, 16'hFFFF);
    edges(14);
    chk("R5 pulse held", plat_rst_o, 1'b1);
    rd(2'd0, d); chk("R10 tmo cleared by pulse", d[0], 1'b0);
    edges(1);
    chk("R5 pulse end", plat_rst_o, 1'b0);
    chk("R7 cfg mult", mult_o, 4'h3);
    rd(2'd0, d); chk("R10 sec/boot kept", d, 16'h0006);
    chk("R3 smi on sec", smi_o, 1'b1);
    wr(2'd0, 16'hFFFC & 16'h0004);
    rd(2'd0, d); chk("R9 boot locked", d[2], 1'b1);
    wr(2'd0, 16'h0002);
    rd(2'd0, d); chk("R8 sec cleared", d, 16'h0004);
    wr(2'd0, 16'h0004);
    rd(2'd0, d); chk("R9 boot cleared", d, 16'h0000);
    wr(2'd0, 16'hFFF8);
    rd(2'd0, d); chk("R8 upper bits zero", d, 16'h0000);

    // Directed: no-reboot, fetched, SMI disabled
    well_reset();
    wr(2'd1, 16'h0001);
    n = 5;
    wr(2'd2, 16'(n));
    mult_cfg_i = 4'h6;
    first_fetch_i = 1'b1; @(posedge clk); @(negedge clk); first_fetch_i = 1'b0;
    kick();
    edges(exp_expire_edges(n));
    rd(2'd0, d); chk("R2 tmo set b", d[0], 1'b1);
    chk("R3 smi disabled", smi_o, exp_smi(1'b0, d));
    wr(2'd0, 16'h0000);
    rd(2'd0, d); chk("R8 write zero keeps", d[0], 1'b1);
    edges(exp_expire_edges(n) - 2);
    rd(2'd0, d); chk("R4 sec early b", d[1], 1'b0);
    edges(1);
    rd(2'd0, d); chk("R4 sec set b", d[1], 1'b1);
    chk("R6 boot not set when fetched", d[2], 1'b0);
    for (int i = 0; i < 20; i++) begin
      if (plat_rst_o !== 1'b0 || mult_o !== 4'h6) begin
        chk("R5 no pulse with no-reboot", {plat_rst_o, mult_o}, {1'b0, 4'h6});
        break;
      end
      edges(1);
    end
    chk("R5 no pulse final", plat_rst_o, 1'b0);
    rst_sys_n = 1'b0; edges(1); rst_sys_n = 1'b1;
    rd(2'd0, d); chk("R10 sys reset", d[1:0], 2'b10);
    well_reset();
    rd(2'd0, d); chk("R10 well reset", d, 16'h0000);

    // Random: kicks hold off expiry, then exact expiry timing
    for (int it = 0; it < 30; it++) begin
      int r;
      int nk;
      r = 4 + int'($urandom % 12);
      wr(2'd2, 16'(r));
      kick();
      nk = int'($urandom % 3);
      for (int j = 0; j < nk; j++) begin
        int k;
        k = 1 + int'($urandom % r);
        edges(k);
        kick();
      end
      rd(2'd0, d); chk("R11 kicks hold off", d[0], 1'b0);
      edges(exp_expire_edges(r) - 1);
      rd(2'd0, d); chk("R2 random early", d[0], 1'b0);
      edges(1);
      rd(2'd0, d); chk("R2 random set", d[0], 1'b1);
      chk("R3 random smi", smi_o, exp_smi(1'b1, d));
      wr(2'd0, 16'h0001);
      rd(2'd0, d); chk("R8 random clear", d[0], 1'b0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule